// File: doc/BRIEF.md
# Bit-Serial Two-Channel Register File

This block holds a bank of general-purpose registers for a core whose datapath is one bit wide. Registers are not read or written through a combinational address port. Instead, the core opens a transfer with a one-cycle request pulse. On the next cycle it supplies two register indices. After a fixed latency the block answers with a one-cycle ready pulse. From the following cycle, one bit of each selected register moves per clock, least significant bit first, for a full word.

Reads and writes run on separate sequencers, and each has its own latency parameter. A read sends out two registers side by side. A write takes two bit streams, and each write lane has its own enable. Register zero is hard-wired to zero. When both write lanes target the same register, lane 0 wins.

Top module: `serial_regfile`

## Requirements
- R1: After reset, `rd_ready`, `wr_ready`, `rd_bit0` and `rd_bit1` are low, and every register reads back as zero.
- R2: Call the cycle in which `rd_req` is high cycle 0. The read indices are sampled in cycle 1, and `rd_ready` is high for exactly cycle RD_LAT (RD_LAT >= 1). Index values outside cycle 1 have no effect.
- R3: Bit k of each selected register appears on `rd_bit0` / `rd_bit1` in cycle RD_LAT+1+k, for k = 0..XLEN-1. Afterwards both outputs return to 0.
- R4: A read of index 0 streams all zeros on that lane.
- R5: Call the cycle in which `wr_req` is high cycle 0. Indices and both enables are sampled in cycle 1, and `wr_ready` is high in cycle WR_LAT (WR_LAT >= 1). Bit k of `wr_bit0` / `wr_bit1` is stored in cycle WR_LAT+1+k.
- R6: A lane whose enable was low in cycle 1 leaves its target register unchanged, while the other lane writes normally.
- R7: Writes to index 0 are discarded.
- R8: If both lanes are enabled and name the same register, the register takes the lane-0 data.
- R9: A request pulse that arrives while the same sequencer is waiting or streaming is ignored, and no extra ready pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Read request pulse |
| rd_idx0 | input | IW | Read lane 0 register index (cycle 1) |
| rd_idx1 | input | IW | Read lane 1 register index (cycle 1) |
| rd_ready | output | 1 | Pulse one cycle before the first read bit |
| rd_bit0 | output | 1 | Read lane 0 serial data |
| rd_bit1 | output | 1 | Read lane 1 serial data |
| wr_req | input | 1 | Write request pulse |
| wr_idx0 | input | IW | Write lane 0 register index (cycle 1) |
| wr_idx1 | input | IW | Write lane 1 register index (cycle 1) |
| wr_en0 | input | 1 | Write lane 0 enable (cycle 1) |
| wr_en1 | input | 1 | Write lane 1 enable (cycle 1) |
| wr_ready | output | 1 | Pulse one cycle before the first write bit is taken |
| wr_bit0 | input | 1 | Write lane 0 serial data |
| wr_bit1 | input | 1 | Write lane 1 serial data |

## Verification
`rd_ready` is due RD_LAT cycles after the request cycle. The read bits follow in the XLEN cycles after that, and the lanes must be back at zero in the next cycle. Write data is driven in cycles WR_LAT+1 onward, and `wr_ready` is checked in cycle WR_LAT. The read driver records the exact cycle in which ready is due. The monitor samples on falling edges and compares that cycle against the one in which it sees the pulse. It then collects exactly XLEN bits before it compares the two words. Indices and enables are scrambled once their sampling cycle has passed, so a design that samples them late produces wrong words.

// File: rtl/srf_pkg.sv
package srf_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_WAIT   = 2'd1,
    PH_STREAM = 2'd2
  } phase_t;
endpackage

// File: rtl/srf_seq.sv
module srf_seq #(
  parameter int LAT  = 2,
  parameter int XLEN = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req,
  output logic                    capture,
  output logic                    ready,
  output logic                    active,
  output logic [$clog2(XLEN)-1:0] bitpos
);
  import srf_pkg::*;

  localparam int CW = (LAT < 2) ? 1 : $clog2(LAT + 1);
  localparam int BW = $clog2(XLEN);

  phase_t        ph;
  logic [CW-1:0] wcnt;

  function automatic logic last_bit(logic [BW-1:0] pos);
    return pos == BW'(XLEN - 1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      wcnt   <= '0;
      bitpos <= '0;
    end else begin
      unique case (ph)
        PH_IDLE: if (req) begin
          ph   <= PH_WAIT;
          wcnt <= CW'(1);
        end
        PH_WAIT: if (wcnt == CW'(LAT)) begin
          ph     <= PH_STREAM;
          bitpos <= '0;
        end else begin
          wcnt <= wcnt + CW'(1);
        end
        PH_STREAM: if (last_bit(bitpos)) ph <= PH_IDLE;
                   else bitpos <= bitpos + BW'(1);
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign capture = (ph == PH_WAIT) && (wcnt == CW'(1));
  assign ready   = (ph == PH_WAIT) && (wcnt == CW'(LAT));
  assign active  = (ph == PH_STREAM);

  // R2
  req_to_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_IDLE && req) |=> capture);

  // R3
  ready_then_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> (active && bitpos == '0 && !ready));

  // R3
  stream_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && last_bit(bitpos)) |=> !active);

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !last_bit(bitpos)) |=> active);
endmodule

// File: rtl/srf_store.sv
module srf_store #(
  parameter int NREG = 32,
  parameter int XLEN = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_active,
  input  logic [$clog2(XLEN)-1:0] wr_pos,
  input  logic [$clog2(NREG)-1:0] wa0,
  input  logic [$clog2(NREG)-1:0] wa1,
  input  logic                    we0,
  input  logic                    we1,
  input  logic                    wd0,
  input  logic                    wd1,
  input  logic [$clog2(NREG)-1:0] ra0,
  input  logic [$clog2(NREG)-1:0] ra1,
  input  logic [$clog2(XLEN)-1:0] rd_pos,
  output logic                    rb0,
  output logic                    rb1
);
  localparam int IW = $clog2(NREG);

  logic [XLEN-1:0] mem [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic hit0, hit1;
    assign hit0 = we0 && (wa0 == IW'(g));
    assign hit1 = we1 && (wa1 == IW'(g)) && !hit0;
    always_ff @(posedge clk) begin
      if (!rst_n) mem[g] <= '0;
      else if (wr_active && (hit0 || hit1)) mem[g][wr_pos] <= hit0 ? wd0 : wd1;
    end
  end

  assign rb0 = mem[ra0][rd_pos];
  assign rb1 = mem[ra1][rd_pos];

  // R8
  lane0_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_active && we0 && we1 && wa0 == wa1) |=> (mem[$past(wa0)][$past(wr_pos)] == $past(wd0)));
endmodule

// File: rtl/serial_regfile.sv
module serial_regfile #(
  parameter int NREG   = 32,
  parameter int XLEN   = 32,
  parameter int RD_LAT = 2,
  parameter int WR_LAT = 1,
  localparam int IW    = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic [IW-1:0] rd_idx0,
  input  logic [IW-1:0] rd_idx1,
  output logic          rd_ready,
  output logic          rd_bit0,
  output logic          rd_bit1,
  input  logic          wr_req,
  input  logic [IW-1:0] wr_idx0,
  input  logic [IW-1:0] wr_idx1,
  input  logic          wr_en0,
  input  logic          wr_en1,
  output logic          wr_ready,
  input  logic          wr_bit0,
  input  logic          wr_bit1
);
  localparam int BW = $clog2(XLEN);

  function automatic logic lane_writes(logic en, logic [IW-1:0] idx);
    return en && (idx != '0);
  endfunction

  logic          rd_cap, rd_act, wr_cap, wr_act;
  logic [BW-1:0] rd_pos, wr_pos;
  logic [IW-1:0] ra0_q, ra1_q, wa0_q, wa1_q;
  logic          we0_q, we1_q, rb0, rb1;

  srf_seq #(.LAT(RD_LAT), .XLEN(XLEN)) u_rd_seq (
    .clk(clk), .rst_n(rst_n), .req(rd_req),
    .capture(rd_cap), .ready(rd_ready), .active(rd_act), .bitpos(rd_pos));

  srf_seq #(.LAT(WR_LAT), .XLEN(XLEN)) u_wr_seq (
    .clk(clk), .rst_n(rst_n), .req(wr_req),
    .capture(wr_cap), .ready(wr_ready), .active(wr_act), .bitpos(wr_pos));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ra0_q <= '0; ra1_q <= '0; wa0_q <= '0; wa1_q <= '0;
      we0_q <= 1'b0; we1_q <= 1'b0;
    end else begin
      if (rd_cap) begin
        ra0_q <= rd_idx0;
        ra1_q <= rd_idx1;
      end
      if (wr_cap) begin
        wa0_q <= wr_idx0;
        wa1_q <= wr_idx1;
        we0_q <= lane_writes(wr_en0, wr_idx0);
        we1_q <= lane_writes(wr_en1, wr_idx1);
      end
    end
  end

  srf_store #(.NREG(NREG), .XLEN(XLEN)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_active(wr_act), .wr_pos(wr_pos),
    .wa0(wa0_q), .wa1(wa1_q), .we0(we0_q), .we1(we1_q),
    .wd0(wr_bit0), .wd1(wr_bit1),
    .ra0(ra0_q), .ra1(ra1_q), .rd_pos(rd_pos),
    .rb0(rb0), .rb1(rb1));

  assign rd_bit0 = rd_act & rb0;
  assign rd_bit1 = rd_act & rb1;

  // R4
  zero_reg_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && ra0_q == '0) |-> !rd_bit0);

  // R7
  zero_reg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cap && wr_idx0 == '0 && wr_idx1 == '0) |=> (!we0_q && !we1_q));
endmodule

// File: tb/serial_regfile_test.sv
module serial_regfile_test;
  localparam int NREG = 32, XLEN = 32, RD_LAT = 2, WR_LAT = 1, IW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_req = 0, wr_req = 0, wr_en0 = 0, wr_en1 = 0, wr_bit0 = 0, wr_bit1 = 0;
  logic [IW-1:0] rd_idx0 = '0, rd_idx1 = '0, wr_idx0 = '0, wr_idx1 = '0;
  logic rd_ready, rd_bit0, rd_bit1, wr_ready;

  serial_regfile #(.NREG(NREG), .XLEN(XLEN), .RD_LAT(RD_LAT), .WR_LAT(WR_LAT)) uut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_idx0(rd_idx0), .rd_idx1(rd_idx1),
    .rd_ready(rd_ready), .rd_bit0(rd_bit0), .rd_bit1(rd_bit1),
    .wr_req(wr_req), .wr_idx0(wr_idx0), .wr_idx1(wr_idx1), .wr_en0(wr_en0),
    .wr_en1(wr_en1), .wr_ready(wr_ready), .wr_bit0(wr_bit0), .wr_bit1(wr_bit1));

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int due; logic [XLEN-1:0] w0, w1; string tag; } exp_t;
  exp_t q[$];
  int pushed = 0, done_n = 0, tests = 0, fails = 0;
  logic [XLEN-1:0] model [NREG];

  task automatic check(bit ok, string req, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected read items when ready is seen
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rd_ready) begin
        if (q.size() == 0) begin
          check(0, "R9", "unexpected rd_ready", 1, 0);
        end else begin
          exp_t e;
          logic [XLEN-1:0] g0, g1;
          e = q.pop_front();
          check(cyc == e.due, "R2", "ready cycle", XLEN'(cyc), XLEN'(e.due));
          for (int k = 0; k < XLEN; k++) begin
            @(negedge clk);
            g0[k] = rd_bit0;
            g1[k] = rd_bit1;
          end
          check(g0 === e.w0, e.tag, "lane0 word", g0, e.w0);
          check(g1 === e.w1, e.tag, "lane1 word", g1, e.w1);
          @(negedge clk);
          check(rd_bit0 == 0 && rd_bit1 == 0, "R3", "idle after stream",
                {rd_bit0, rd_bit1}, 0);
          done_n++;
        end
      end
    end
  end

  task automatic issue_read(logic [IW-1:0] a, logic [IW-1:0] b, string tag);
    exp_t e;
    @(negedge clk);
    rd_req = 1;
    e.due = cyc + RD_LAT; e.w0 = model[a]; e.w1 = model[b]; e.tag = tag;
    q.push_back(e); pushed++;
    @(negedge clk);
    rd_req = 0; rd_idx0 = a; rd_idx1 = b;
    @(negedge clk);
    rd_idx0 = ~a; rd_idx1 = ~b;
  endtask

  task automatic do_read(logic [IW-1:0] a, logic [IW-1:0] b, string tag);
    issue_read(a, b, tag);
    wait (done_n == pushed);
  endtask

  task automatic do_write(logic [IW-1:0] a, logic [IW-1:0] b, logic e0, logic e1,
                          logic [XLEN-1:0] d0, logic [XLEN-1:0] d1);
    @(negedge clk);
    wr_req = 1;
    @(negedge clk);
    wr_req = 0; wr_idx0 = a; wr_idx1 = b; wr_en0 = e0; wr_en1 = e1;
    for (int i = 1; i < WR_LAT; i++) @(negedge clk);
    check(wr_ready == 1, "R5", "wr_ready cycle", XLEN'(wr_ready), 1);
    for (int k = 0; k < XLEN; k++) begin
      @(negedge clk);
      if (k == 0) begin
        wr_idx0 = ~a; wr_idx1 = ~b; wr_en0 = ~e0; wr_en1 = ~e1;
      end
      wr_bit0 = d0[k]; wr_bit1 = d1[k];
    end
    @(negedge clk);
    wr_bit0 = 0; wr_bit1 = 0; wr_en0 = 0; wr_en1 = 0;
    if (e1 && b != 0) model[b] = d1;
    if (e0 && a != 0) model[a] = d0;
  endtask

  initial begin
    #(200000 * 10);
    check(0, "R1", "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!rd_ready && !wr_ready && !rd_bit0 && !rd_bit1, "R1", "reset outputs",
          {rd_ready, wr_ready, rd_bit0, rd_bit1}, 0);
    rst_n = 1;
    do_read(5, 31, "R1");
    // R3 R5 plain write of two registers
    do_write(5, 9, 1, 1, 32'hA5A5_3C3C, 32'h0000_1234);
    do_read(5, 9, "R3");
    // R6 lane 0 disabled
    do_write(5, 10, 0, 1, 32'hFFFF_FFFF, 32'hC0DE_0001);
    do_read(5, 10, "R6");
    // R6 lane 1 disabled
    do_write(11, 10, 1, 0, 32'h8BAD_F00D, 32'h1111_2222);
    do_read(11, 10, "R6");
    // R7 write to register zero, R4 read of zero
    do_write(0, 12, 1, 1, 32'hDEAD_BEEF, 32'h7654_3210);
    do_read(0, 12, "R4_R7");
    // R8 both lanes on the same register
    do_write(20, 20, 1, 1, 32'h1111_1111, 32'h2222_2222);
    do_read(20, 20, "R8");
    // R3 edge bit patterns
    do_write(31, 1, 1, 1, 32'hFFFF_FFFF, 32'h8000_0001);
    do_read(31, 1, "R3");
    // R9 request during a busy read is ignored
    issue_read(9, 11, "R9");
    repeat (5) @(negedge clk);
    rd_req = 1;
    @(negedge clk);
    rd_req = 0;
    wait (done_n == pushed);
    repeat (RD_LAT + 4) @(negedge clk);
    check(done_n == pushed && q.size() == 0, "R9", "no extra read", XLEN'(done_n), XLEN'(pushed));
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule